// File: doc/BRIEF.md
# Bus Lane Parity Generator and Checker

This block produces and verifies even parity for a 64-bit multiplexed address/data bus with active-low command/byte-enable lines. The bus is split into two lanes: the low lane covers data bits 31:0 with enables 3:0, and the high lane covers data bits 63:32 with enables 7:4. Each lane has its own parity bit. In every cycle the block samples the bus, works out whether that cycle carried an address or a data transfer, and decides which agent put the data on the bus.

When this agent was the data source, the block presents the registered parity one clock later and raises the output enable for that lane. When the other agent was the source, the block compares the parity bit that arrives one clock later with its own registered value. On a mismatch it raises a one-cycle error pulse. A role input selects initiator or target behaviour, a direction input selects write or read, and a wide-mode input enables the high lane. The pad drivers and the error-reporting policy are outside this block.

Top module: `pci_parity_gen`

## Requirements
- R1: Whenever `par_out_en` is high, `par_out` equals the XOR of `ad_in[31:0]` and `cbe_n_in[3:0]` as sampled in the previous cycle, so that the total count of ones is even.
- R2: Whenever `par64_out_en` is high, `par64_out` equals the XOR of `ad_in[63:32]` and `cbe_n_in[7:4]` from the previous cycle.
- R3: The address phase is the cycle in which `frame_n` is low while the bus was idle. An initiator (`is_master`=1) drives parity in the following cycle. A target does not.
- R4: In a write (`is_write`=1), an initiator drives parity in the cycle after each data-phase cycle that has `irdy_n` low. It does not drive parity after data-phase cycles that have `irdy_n` high.
- R5: In a read, a target drives parity in the cycle after each data-phase cycle that has `trdy_n` low. A target never drives parity for address or write-data cycles, and an initiator never drives it for read data.
- R6: The bus becomes idle after a cycle with `frame_n` high and both `irdy_n` and `trdy_n` low (the final transfer completes), or after a cycle with `frame_n` and `irdy_n` both high. Both enables are low in the cycle after an idle-bus cycle.
- R7: When `wide_mode` is 0, `par64_out_en` stays low and `par64_err` never pulses, whatever arrives on `par64_in`.
- R8: For a cycle whose data came from the other agent, `par_err` (or `par64_err`) pulses for exactly one cycle, two cycles later, if `par_in` (`par64_in`) sampled one cycle later differs from that cycle's even parity. It stays low if the two match. A target checks address and write-data cycles, and an initiator checks read-data cycles.
- R9: During and right after reset, both enables and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_in | input | 64 | Sampled address/data bus |
| cbe_n_in | input | 8 | Sampled command/byte enables, active low |
| frame_n | input | 1 | Sampled frame, active low |
| irdy_n | input | 1 | Sampled initiator ready, active low |
| trdy_n | input | 1 | Sampled target ready, active low |
| is_master | input | 1 | 1 when this agent is the initiator |
| is_write | input | 1 | 1 for a write transaction |
| wide_mode | input | 1 | 1 when the high lane takes part |
| par_in | input | 1 | Sampled low-lane parity |
| par64_in | input | 1 | Sampled high-lane parity |
| par_out | output | 1 | Low-lane parity to drive |
| par_out_en | output | 1 | Drive enable for the low-lane parity |
| par64_out | output | 1 | High-lane parity to drive |
| par64_out_en | output | 1 | Drive enable for the high-lane parity |
| par_err | output | 1 | Low-lane receive parity error pulse |
| par64_err | output | 1 | High-lane receive parity error pulse |

## Verification
The embedded properties check on every cycle the properties that hold on their own: the value of each driven parity bit against the previous cycle's lane contents, that a target never enables parity after a write cycle, that an idle bus turns both enables off, that the high lane stays silent in narrow mode, and that an error pulse only follows a mismatch between the received bit and the stored expectation. Only the bench scenarios show whether each enable appears exactly when it should. These scenarios cover initiator and target roles, both directions, wait states from either side, multi-phase bursts and corrupted incoming parity, and they show that matching parity produces no pulse.

// File: rtl/pci_parity_gen.sv
module pci_parity_gen #(
  parameter int LANE_W = 32,
  parameter int BE_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*LANE_W-1:0] ad_in,
  input  logic [2*BE_W-1:0]   cbe_n_in,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic                trdy_n,
  input  logic                is_master,
  input  logic                is_write,
  input  logic                wide_mode,
  input  logic                par_in,
  input  logic                par64_in,
  output logic                par_out,
  output logic                par_out_en,
  output logic                par64_out,
  output logic                par64_out_en,
  output logic                par_err,
  output logic                par64_err
);

  localparam int AD_W = 2 * LANE_W;
  localparam int CB_W = 2 * BE_W;

  logic busy_q;
  logic lo_q, hi_q;
  logic drv_q, drv64_q;
  logic chk_q, chk64_q;
  logic err_q, err64_q;

  wire lo_par   = ^{ad_in[LANE_W-1:0], cbe_n_in[BE_W-1:0]};
  wire hi_par   = ^{ad_in[AD_W-1:LANE_W], cbe_n_in[CB_W-1:BE_W]};

  wire addr_ph  = !frame_n && !busy_q;
  wire from_ini = addr_ph || (busy_q && is_write && !irdy_n);
  wire from_tgt = busy_q && !is_write && !trdy_n;
  wire own_src  = is_master ? from_ini : from_tgt;
  wire peer_src = is_master ? from_tgt : from_ini;
  wire busy_d   = !frame_n || (!irdy_n && trdy_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      lo_q    <= 1'b0;
      hi_q    <= 1'b0;
      drv_q   <= 1'b0;
      drv64_q <= 1'b0;
      chk_q   <= 1'b0;
      chk64_q <= 1'b0;
      err_q   <= 1'b0;
      err64_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      lo_q    <= lo_par;
      hi_q    <= hi_par;
      drv_q   <= own_src;
      drv64_q <= own_src && wide_mode;
      chk_q   <= peer_src;
      chk64_q <= peer_src && wide_mode;
      err_q   <= chk_q && (par_in != lo_q);
      err64_q <= chk64_q && (par64_in != hi_q);
    end
  end

  assign par_out      = lo_q;
  assign par64_out    = hi_q;
  assign par_out_en   = drv_q;
  assign par64_out_en = drv64_q;
  assign par_err      = err_q;
  assign par64_err    = err64_q;

  assert_lo_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
    par_out_en |-> (par_out == ^{$past(ad_in[LANE_W-1:0]), $past(cbe_n_in[BE_W-1:0])}));

  assert_hi_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    par64_out_en |-> (par64_out == ^{$past(ad_in[AD_W-1:LANE_W]), $past(cbe_n_in[CB_W-1:BE_W])}));

  assert_tgt_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (par_out_en && !$past(is_master)) |-> !$past(is_write));

  assert_idle_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_n) && $past(irdy_n)) |-> (!par_out_en && !par64_out_en));

  assert_narrow_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wide_mode) |-> !par64_out_en);

  assert_narrow_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wide_mode, 2) |-> !par64_err);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> ($past(par_in) != $past(par_out)));

  assert_err64_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    par64_err |-> ($past(par64_in) != $past(par64_out)));

  assert_no_self_check_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_q && chk_q));

endmodule

// File: tb/pci_parity_gen_tb.sv
module pci_parity_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ad_in = '0;
  logic [7:0]  cbe_n_in = '1;
  logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic        is_master = 1'b0, is_write = 1'b0, wide_mode = 1'b0;
  logic        par_in = 1'b0, par64_in = 1'b0;
  logic        par_out, par_out_en, par64_out, par64_out_en, par_err, par64_err;

  always #10 clk = ~clk;

  pci_parity_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_n_in(cbe_n_in),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .is_master(is_master), .is_write(is_write), .wide_mode(wide_mode),
    .par_in(par_in), .par64_in(par64_in),
    .par_out(par_out), .par_out_en(par_out_en),
    .par64_out(par64_out), .par64_out_en(par64_out_en),
    .par_err(par_err), .par64_err(par64_err)
  );

  int checks = 0;
  int fails  = 0;

  // Reference state derived from the requirements
  logic m_busy = 0;
  logic e_drv = 0, e_drv64 = 0, e_lo = 0, e_hi = 0;
  logic e_err = 0, e_err64 = 0;
  logic p_chk = 0, p_chk64 = 0, p_lo = 0, p_hi = 0;

  task automatic chk(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk(par_out_en === e_drv, "R3/R4/R5/R6 low enable", {1'b0, par_out_en}, {1'b0, e_drv});
    chk(par64_out_en === e_drv64, "R7/R6 high enable", {1'b0, par64_out_en}, {1'b0, e_drv64});
    if (e_drv) chk(par_out === e_lo, "R1 low parity", {1'b0, par_out}, {1'b0, e_lo});
    if (e_drv64) chk(par64_out === e_hi, "R2 high parity", {1'b0, par64_out}, {1'b0, e_hi});
    chk(par_err === e_err, "R8 low error", {1'b0, par_err}, {1'b0, e_err});
    chk(par64_err === e_err64, "R8/R7 high error", {1'b0, par64_err}, {1'b0, e_err64});
  endtask

  // One bus cycle: check the previous edge's result, apply stimulus, update model
  task automatic step(input logic f, input logic i, input logic t,
                      input logic [63:0] ad, input logic [7:0] cb,
                      input bit bad, input bit bad64);
    logic lo, hi, addr, ini, tgt, own, peer;
    @(negedge clk);
    check_outputs();
    frame_n = f; irdy_n = i; trdy_n = t; ad_in = ad; cbe_n_in = cb;
    par_in   = p_lo ^ bad;
    par64_in = p_hi ^ bad64;
    lo   = ^{ad[31:0], cb[3:0]};
    hi   = ^{ad[63:32], cb[7:4]};
    addr = !f && !m_busy;
    ini  = addr || (m_busy && is_write && !i);
    tgt  = m_busy && !is_write && !t;
    own  = is_master ? ini : tgt;
    peer = is_master ? tgt : ini;
    e_err   = p_chk && (par_in != p_lo);
    e_err64 = p_chk64 && (par64_in != p_hi);
    e_drv   = own;
    e_drv64 = own && wide_mode;
    e_lo = lo; e_hi = hi;
    p_chk = peer; p_chk64 = peer && wide_mode;
    p_lo = lo; p_hi = hi;
    m_busy = !f || (!i && t);
  endtask

  task automatic run_xact(input logic [12:0] sc);
    int nph, nw;
    logic [63:0] d;
    logic [7:0] cb;
    is_master = sc[12]; is_write = sc[11]; wide_mode = sc[10];
    nph = int'(sc[7:4]); nw = int'(sc[3:0]);
    step(1'b0, 1'b1, 1'b1, {$urandom, $urandom}, 8'($urandom), sc[9], sc[8]);
    for (int p = 0; p < nph; p++) begin
      bit last = (p == nph - 1);
      d  = {$urandom, $urandom};
      cb = 8'($urandom);
      for (int k = 0; k < nw; k++) begin
        if (is_write && k == 0)
          step(1'b0, 1'b1, 1'b1, {$urandom, $urandom}, 8'($urandom), sc[9], sc[8]);
        else if (is_write)
          step(!last ? 1'b0 : 1'b1, 1'b0, 1'b1, d, cb, sc[9], sc[8]);
        else
          step(!last ? 1'b0 : 1'b1, 1'b0, 1'b1, {$urandom, $urandom}, 8'($urandom), sc[9], sc[8]);
      end
      step(!last ? 1'b0 : 1'b1, 1'b0, 1'b0, d, cb, sc[9], sc[8]);
    end
    step(1'b1, 1'b1, 1'b1, {$urandom, $urandom}, 8'($urandom), sc[9], sc[8]);
    step(1'b1, 1'b1, 1'b1, {$urandom, $urandom}, 8'($urandom), sc[9], sc[8]);
  endtask

  // [12] initiator [11] write [10] wide [9] corrupt low [8] corrupt high [7:4] phases [3:0] waits
  localparam int NS = 12;
  localparam logic [12:0] SCEN [NS] = '{
    13'b1_1_1_0_0_0011_0000,  // R3 R4 R1 R2 initiator write burst
    13'b1_1_1_0_0_0010_0011,  // R4 initiator write with waits
    13'b1_0_1_0_0_0010_0010,  // R5 initiator read, checks read data
    13'b0_0_1_0_0_0011_0001,  // R5 target read drives
    13'b0_1_1_0_0_0010_0010,  // R5 target write checks only
    13'b0_1_1_1_0_0001_0000,  // R8 target sees bad low parity
    13'b0_1_1_0_1_0010_0001,  // R8 target sees bad high parity
    13'b1_0_1_1_1_0010_0001,  // R8 initiator read, both corrupt
    13'b1_1_0_0_1_0010_0001,  // R7 narrow initiator write
    13'b0_1_0_1_1_0001_0000,  // R7 narrow target, high corrupt ignored
    13'b0_0_0_0_0_0001_0010,  // R7 narrow target read
    13'b1_0_1_0_0_0001_0000   // R6 single read phase
  };

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!par_out_en && !par64_out_en, "R9 enables in reset", {par_out_en, par64_out_en}, 2'b00);
    chk(!par_err && !par64_err, "R9 errors in reset", {par_err, par64_err}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!par_out_en && !par64_out_en && !par_err && !par64_err, "R9 after reset",
        {par_out_en, par_err}, 2'b00);
    for (int s = 0; s < NS; s++) run_xact(SCEN[s]);
    // directed: back-to-back transactions without idle cycle between them
    is_master = 1'b1; is_write = 1'b1; wide_mode = 1'b1;
    step(1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_0000_0001, 8'h0F, 0, 0);  // R1 R2 odd/even corners
    step(1'b1, 1'b0, 1'b0, 64'h0, 8'h00, 0, 0);                  // R6 final transfer
    step(1'b0, 1'b1, 1'b1, 64'h8000_0000_8000_0000, 8'hFF, 0, 0);  // R3 new address at once
    step(1'b1, 1'b0, 1'b0, 64'h1, 8'h01, 0, 0);
    step(1'b1, 1'b1, 1'b1, 64'h0, 8'h00, 0, 0);
    step(1'b1, 1'b1, 1'b1, 64'h0, 8'h00, 0, 0);
    @(negedge clk);
    check_outputs();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule